// File: doc/BRIEF.md
# Multi-carrier PSK symbol mapper

This block builds the frequency-domain input vector of a sixteen-subcarrier multicarrier transmitter. For every symbol period it takes three bits per carrier, either from an internal pseudo-random sequence or from an external test input, and turns them into one signed complex value per carrier. Each carrier is mapped independently, so the vector can mix BPSK, Gray-coded QPSK and Gray-coded 8-PSK carriers.

Each carrier has its own mode register, which software-free control logic writes one carrier at a time. A write never disturbs a vector that has already been built; it is used from the next vector onward. The constellation points are formed with subtractors and constant scaling, not a lookup table. The vector is passed to the downstream inverse transform with a valid/ready handshake, and all carriers are presented in the same cycle.

Top module: `mc_psk_mapper`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and every carrier mode is QPSK. The first rising edge after reset release builds a vector, and `out_valid` is 1 from the cycle after that edge.
- R2: A new vector is loaded on a rising edge where `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, both output buses hold their values. Once `out_valid` is 1 it stays 1.
- R3: The internal source is a 23-bit register seeded with 0x5A5A5 at reset. One step computes f = s[22] xor s[17] and then sets s = {s[21:0], f}. Each load takes 48 steps, and the f of step k becomes source bit k. Carrier c uses source bits 3c (b0), 3c+1 (b1) and 3c+2 (b2).
- R4: If `ext_en` is 1 at a load, the source bits are taken from `ext_bits` with the same bit positions. The internal register still advances by 48 steps on every load.
- R5: In BPSK mode (mode code 00) a carrier maps b0=0 to (+A, 0) and b0=1 to (-A, 0). A is the parameter `AMP`, 1448 by default.
- R6: In QPSK mode (code 01, and also the reserved code 11) codeword {b1,b0} maps as follows: 00 to (+A,+A), 01 to (-A,+A), 11 to (-A,-A), 10 to (+A,-A).
- R7: In 8-PSK mode (code 10) codeword {b2,b1,b0} equals k xor (k>>1) for the point at angle k*45 degrees, with I = A*cos and Q = A*sin. A component of magnitude 0.7071 is D = (A*7071+5000)/10000 in integer division, which is 1024 by default.
- R8: `mode_wr` writes `mode_val` into the mode of carrier `mode_idx` on a rising edge. A load on that same edge still uses the old mode. A held vector is never changed by a write.
- R9: The I value of carrier c is at `out_i[12c+11:12c]`, and its Q value is at the same position in `out_q`. Both are 12-bit two's complement and carry the exact constellation value with no truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_idx | input | 4 | Carrier selected by the write |
| mode_val | input | 2 | Mode code: 00 BPSK, 01 QPSK, 10 8-PSK, 11 QPSK |
| ext_en | input | 1 | Take the codeword bits from `ext_bits` |
| ext_bits | input | 48 | External codeword bits, 3 per carrier |
| out_ready | input | 1 | Downstream accepts the vector |
| out_valid | output | 1 | Output vector is valid |
| out_i | output | 192 | In-phase values, 16 x 12 bits |
| out_q | output | 192 | Quadrature values, 16 x 12 bits |

## Verification
A mode write and a vector load can happen on the same edge. The mapping must then use the old mode, and the new mode must appear only in the following vector. The bench provokes this by issuing writes while `out_ready` is high, and also during stalls, where the held vector must not change. A behavioural model maps the bits first and applies the write afterwards in each cycle. Its per-carrier results are compared with the outputs on every clock, across random mode mixes, external and internal bits, and stall patterns.

// File: rtl/mcpsk_pkg.sv
package mcpsk_pkg;
   typedef enum logic [1:0] {
      MODE_BPSK = 2'b00,
      MODE_QPSK = 2'b01,
      MODE_8PSK = 2'b10,
      MODE_RSVD = 2'b11
   } mcpsk_mode_e;

   localparam int CW_BITS = 3;
endpackage

// File: rtl/mcpsk_lfsr.sv
module mcpsk_lfsr #(
   parameter int          WIDTH = 23,
   parameter int          TAP   = 18,
   parameter int unsigned SEED  = 32'h0005_A5A5,
   parameter int          NBITS = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [NBITS-1:0] bits_o
);
   localparam logic [WIDTH-1:0] SEED_V = SEED[WIDTH-1:0];

   if (SEED_V == '0) begin : g_bad_seed
      $error("mcpsk_lfsr: seed must be nonzero");
   end
   if (TAP < 1 || TAP >= WIDTH) begin : g_bad_tap
      $error("mcpsk_lfsr: tap out of range");
   end

   logic [WIDTH-1:0] state_q, state_n;

   // leap NBITS steps in one cycle
   always_comb begin
      logic [WIDTH-1:0] s;
      logic             fb;
      s      = state_q;
      fb     = 1'b0;
      bits_o = '0;
      for (int k = 0; k < NBITS; k++) begin
         fb        = s[WIDTH-1] ^ s[TAP-1];
         s         = {s[WIDTH-2:0], fb};
         bits_o[k] = fb;
      end
      state_n = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= SEED_V;
      else if (adv) state_q <= state_n;
   end

   p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
endmodule

// File: rtl/mcpsk_mode_bank.sv
module mcpsk_mode_bank #(
   parameter int NCAR  = 16,
   parameter int IDX_W = $clog2(NCAR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [1:0]        val,
   output logic [2*NCAR-1:0] modes_o
);
   import mcpsk_pkg::*;

   for (genvar c = 0; c < NCAR; c++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            modes_o[2*c +: 2] <= MODE_QPSK;
         else if (wr && (idx == IDX_W'(c)))
            modes_o[2*c +: 2] <= val;
      end
   end

   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(modes_o));
endmodule

// File: rtl/mcpsk_carrier_map.sv
module mcpsk_carrier_map #(
   parameter int W    = 12,
   parameter int AMP  = 1448,
   parameter int DIAG = 1024
) (
   input  logic                        [1:0] mode,
   input  logic [mcpsk_pkg::CW_BITS-1:0]     cw,
   output logic                      [W-1:0] i_o,
   output logic                      [W-1:0] q_o
);
   import mcpsk_pkg::*;

   localparam int XW = W + 2;
   localparam logic signed [XW-1:0] A_X = XW'(AMP);
   localparam logic signed [XW-1:0] D_X = XW'(DIAG);

   logic signed [XW-1:0] i_x, q_x, mag;
   logic b0, b1, b2, k0, k1, k2;
   logic i_pos, i_neg, q_pos, q_neg;

   always_comb begin
      b0 = cw[0];
      b1 = cw[1];
      b2 = cw[2];
      // inverse Gray: position on the 8-point circle
      k2 = b2;
      k1 = b2 ^ b1;
      k0 = k1 ^ b0;
      mag   = k0 ? D_X : A_X;
      i_pos = (~k2 & ~k1) | (k2 & k1 & k0);
      i_neg = (~k2 & k1 & k0) | (k2 & ~k1);
      q_pos = ~k2 & (k1 | k0);
      q_neg =  k2 & (k1 | k0);
      case (mcpsk_mode_e'(mode))
         MODE_BPSK: begin
            i_x = A_X - ((A_X <<< 1) & {XW{b0}});
            q_x = '0;
         end
         MODE_8PSK: begin
            i_x = (i_pos ? mag : '0) - (i_neg ? mag : '0);
            q_x = (q_pos ? mag : '0) - (q_neg ? mag : '0);
         end
         default: begin
            i_x = A_X - ((A_X <<< 1) & {XW{b0}});
            q_x = A_X - ((A_X <<< 1) & {XW{b1}});
         end
      endcase
      i_o = i_x[W-1:0];
      q_o = q_x[W-1:0];
   end
endmodule

// File: rtl/mc_psk_mapper.sv
module mc_psk_mapper #(
   parameter int          NCAR      = 16,
   parameter int          SAMPLE_W  = 12,
   parameter int          AMP       = 1448,
   parameter int          LFSR_W    = 23,
   parameter int          LFSR_TAP  = 18,
   parameter int unsigned LFSR_SEED = 32'h0005_A5A5,
   localparam int         IDX_W     = $clog2(NCAR),
   localparam int         BITS_W    = NCAR * mcpsk_pkg::CW_BITS,
   localparam int         VEC_W     = NCAR * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [IDX_W-1:0]  mode_idx,
   input  logic [1:0]        mode_val,
   input  logic              ext_en,
   input  logic [BITS_W-1:0] ext_bits,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_i,
   output logic [VEC_W-1:0]  out_q
);
   import mcpsk_pkg::*;

   localparam int DIAG = (AMP * 7071 + 5000) / 10000;
   localparam logic [SAMPLE_W-1:0] A_POS = SAMPLE_W'(AMP);
   localparam logic [SAMPLE_W-1:0] A_NEG = SAMPLE_W'(-AMP);

   if (AMP <= 0 || AMP >= (1 << (SAMPLE_W - 1))) begin : g_bad_amp
      $error("mc_psk_mapper: AMP does not fit SAMPLE_W");
   end
   if (NCAR < 2) begin : g_bad_ncar
      $error("mc_psk_mapper: NCAR must be at least 2");
   end

   logic              load;
   logic [BITS_W-1:0] lfsr_bits, src_bits;
   logic [2*NCAR-1:0] modes;
   logic [VEC_W-1:0]  nxt_i, nxt_q;

   assign load     = !out_valid || out_ready;
   assign src_bits = ext_en ? ext_bits : lfsr_bits;

   mcpsk_lfsr #(
      .WIDTH(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED), .NBITS(BITS_W)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv(load), .bits_o(lfsr_bits)
   );

   mcpsk_mode_bank #(.NCAR(NCAR), .IDX_W(IDX_W)) u_modes (
      .clk(clk), .rst_n(rst_n), .wr(mode_wr), .idx(mode_idx),
      .val(mode_val), .modes_o(modes)
   );

   for (genvar c = 0; c < NCAR; c++) begin : g_car
      mcpsk_carrier_map #(.W(SAMPLE_W), .AMP(AMP), .DIAG(DIAG)) u_map (
         .mode(modes[2*c +: 2]),
         .cw  (src_bits[CW_BITS*c +: CW_BITS]),
         .i_o (nxt_i[SAMPLE_W*c +: SAMPLE_W]),
         .q_o (nxt_q[SAMPLE_W*c +: SAMPLE_W])
      );

      p_bpsk_q_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         load && (modes[2*c +: 2] == MODE_BPSK)
         |=> out_q[SAMPLE_W*c +: SAMPLE_W] == '0);

      p_qpsk_corner_r6: assert property (@(posedge clk) disable iff (!rst_n)
         load && (modes[2*c +: 2] == MODE_QPSK)
         |=> (out_i[SAMPLE_W*c +: SAMPLE_W] == A_POS || out_i[SAMPLE_W*c +: SAMPLE_W] == A_NEG)
          && (out_q[SAMPLE_W*c +: SAMPLE_W] == A_POS || out_q[SAMPLE_W*c +: SAMPLE_W] == A_NEG));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_i     <= nxt_i;
         out_q     <= nxt_q;
      end
   end

   p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

   p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> out_valid);
endmodule

// File: tb/tb_mc_psk_mapper.sv
module tb_mc_psk_mapper;
   localparam int NC = 16;
   localparam int W  = 12;
   localparam int A  = 1448;
   localparam int D  = (A * 7071 + 5000) / 10000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [3:0]    mode_idx = '0;
   logic [1:0]    mode_val = '0;
   logic          ext_en = 1'b0;
   logic [47:0]   ext_bits = '0;
   logic          out_ready = 1'b0;
   logic          out_valid;
   logic [NC*W-1:0] out_i, out_q;

   int compared = 0, mismatched = 0, cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mc_psk_mapper dut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_idx(mode_idx),
      .mode_val(mode_val), .ext_en(ext_en), .ext_bits(ext_bits),
      .out_ready(out_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   // ---------------- reference model ----------------
   logic [22:0] m_lfsr;
   int          m_mode [NC];
   bit          m_valid;
   int          m_i [NC], m_q [NC];
   string       m_tag [NC];

   function automatic void ref_map(input int mode, input int cw,
                                   output int ei, output int eq, output string tag);
      int k;
      k = 0;
      if (mode == 0) begin
         ei = (cw & 1) ? -A : A;  eq = 0;  tag = "R5";
      end else if (mode == 2) begin
         for (int p = 0; p < 8; p++) if ((p ^ (p >> 1)) == cw) k = p;
         case (k)
            0: begin ei =  A; eq =  0; end
            1: begin ei =  D; eq =  D; end
            2: begin ei =  0; eq =  A; end
            3: begin ei = -D; eq =  D; end
            4: begin ei = -A; eq =  0; end
            5: begin ei = -D; eq = -D; end
            6: begin ei =  0; eq = -A; end
            default: begin ei = D; eq = -D; end
         endcase
         tag = "R7";
      end else begin
         case (cw & 3)
            0: begin ei =  A; eq =  A; end
            1: begin ei = -A; eq =  A; end
            3: begin ei = -A; eq = -A; end
            default: begin ei = A; eq = -A; end
         endcase
         tag = "R6";
      end
   endfunction

   always @(posedge clk) begin
      logic [47:0] bv;
      logic        nb;
      int          ei, eq;
      string       tg;
      if (!rst_n) begin
         m_lfsr  = 23'h5A5A5;
         m_valid = 0;
         for (int c = 0; c < NC; c++) m_mode[c] = 1;
      end else begin
         if (!m_valid || out_ready) begin
            for (int k = 0; k < 48; k++) begin
               nb     = m_lfsr[22] ^ m_lfsr[17];
               m_lfsr = {m_lfsr[21:0], nb};
               bv[k]  = nb;
            end
            if (ext_en) bv = ext_bits;
            for (int c = 0; c < NC; c++) begin
               ref_map(m_mode[c], int'(bv[3*c +: 3]), ei, eq, tg);
               m_i[c]   = ei;
               m_q[c]   = eq;
               m_tag[c] = {tg, ext_en ? " R4" : " R3"};
            end
            m_valid = 1;
         end
         // R8: write lands after this edge's mapping
         if (mode_wr) m_mode[mode_idx] = int'(mode_val);
      end
   end

   task automatic compare_all();
      int ai, aq;
      compared++;
      if (out_valid !== m_valid) begin
         mismatched++;
         $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, m_valid);
      end
      if (m_valid) begin
         for (int c = 0; c < NC; c++) begin
            // R9: carrier c sits at bits [12c+11:12c]
            ai = int'($signed(out_i[W*c +: W]));
            aq = int'($signed(out_q[W*c +: W]));
            compared++;
            if (ai != m_i[c] || aq != m_q[c]) begin
               mismatched++;
               $display("FAIL %s R9 carrier %0d actual (%0d,%0d) expected (%0d,%0d)",
                        m_tag[c], c, ai, aq, m_i[c], m_q[c]);
            end
         end
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle_inputs();
      mode_wr = 0; ext_en = 0;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         compared++;
         if (out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 out_valid in reset actual %0b expected 0", out_valid);
         end
      end
      rst_n = 1; out_ready = 0;
      cycle();
      compared++;
      if (out_valid !== 1'b1) begin
         mismatched++;
         $display("FAIL R1 first vector valid actual %0b expected 1", out_valid);
      end
      // R1 R3 R6: default QPSK from internal source, with and without stalls
      for (int n = 0; n < 30; n++) begin out_ready = (n % 4 != 3); cycle(); end
      // R5 R6 R7: mixed modes, writes coinciding with loads (R8)
      for (int c = 0; c < NC; c++) begin
         out_ready = 1; mode_wr = 1; mode_idx = 4'(c); mode_val = 2'(c % 4);
         cycle();
      end
      idle_inputs();
      for (int n = 0; n < 10; n++) cycle();
      // R8: writes during a stall must not touch the held vector
      out_ready = 0;
      for (int c = 0; c < NC; c++) begin
         mode_wr = 1; mode_idx = 4'(c); mode_val = 2'((c + 1) % 3);
         cycle();
      end
      idle_inputs(); out_ready = 1;
      for (int n = 0; n < 4; n++) cycle();
      // R7 R4: every 8-PSK codeword through the external input
      for (int c = 0; c < NC; c++) begin
         mode_wr = 1; mode_idx = 4'(c); mode_val = 2'b10; cycle();
      end
      mode_wr = 0; ext_en = 1;
      for (int r = 0; r < 8; r++) begin
         for (int c = 0; c < NC; c++) ext_bits[3*c +: 3] = 3'((c + r) % 8);
         cycle();
      end
      // R5: BPSK with both bit values
      for (int c = 0; c < NC; c++) begin
         mode_wr = 1; mode_idx = 4'(c); mode_val = 2'b00; ext_bits = '0; cycle();
      end
      mode_wr = 0; ext_bits = '1; cycle(); cycle();
      // random mix of everything
      for (int n = 0; n < 600; n++) begin
         out_ready = ($urandom % 3) != 0;
         mode_wr   = ($urandom % 2) != 0;
         mode_idx  = 4'($urandom);
         mode_val  = 2'($urandom);
         ext_en    = ($urandom % 3) == 0;
         ext_bits  = {16'($urandom), 32'($urandom)};
         cycle();
      end
      idle_inputs(); out_ready = 1;
      cycle(); cycle();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         mismatched++;
         $display("FAIL R2 watchdog expired: cycles actual %0d expected below 20000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule